// File: doc/BRIEF.md
# High-Voltage Interlock Permission Arbiter

This block decides whether the high-voltage stage may be energised and whether an exposure may run. It takes a set of hardwired OK signals (emergency-stop loop, door/cover, coolant flow, fan/rotor, thermal limit, insulation monitor, discharge-proof pass and a protection-fault line), an exposure command, a service reset and an event acknowledge. It produces an HV enable, an exposure permit, an exposure-active flag and a one-cycle pulse that marks a fault clear as accepted.

Every OK input is active high. A low, open or missing input therefore denies. Each input has its own filter and its own latch rule. Some latches depend on whether an exposure is running at the moment the input drops. No input can force HV enable on. The only way to release a latch is an accepted service clear.

For each input the block reports a live denial bit. It also holds the first cause of the current denial episode and the value of a free-running counter taken at the moment that episode began.

Top module: `hv_permit_arbiter`

## Requirements
- R1: During reset and directly after it, `hv_en_o`, `expo_permit_o` and `expo_active_o` are 0, and `reason_o` is 8'hFF while reset is held. In the first cycle after release, every filtered input still reads as not OK, so with all inputs high `reason_o` reads 8'h7E.
- R2: The emergency-stop input (`estop_ok_i`) has no filter. When it is low, `hv_en_o` is 0 after the next clock edge. A latch (reason bit 0) keeps HV off after the input returns, until a clear is accepted.
- R3: The door input passes through a filter of `DOOR_DEPTH` cycles (default 3). A low pulse shorter than that has no effect. A longer drop removes HV enable. If no exposure is active, the door state takes effect again as soon as it returns, with no latch.
- R4: A filtered door drop while `expo_active_o` is 1 sets a latch that holds reason bit 1 and keeps HV off until a clear is accepted.
- R5: The coolant input is filtered over `COOL_DEPTH` cycles. The `COOL_DROPS`-th filtered drop (default 3) sets a latch (reason bit 2) that vetoes HV. The drop count returns to zero after `COOL_CALM` consecutive filtered-OK cycles (default 64), and also when a clear is accepted.
- R6: Coolant, fan and thermal are operational permits. While unlatched, they withdraw only the exposure permit and leave `hv_en_o` at 1. A filtered fan drop while an exposure is active sets a latch (reason bit 3) that vetoes HV.
- R7: A falling edge of the filtered insulation input (reason bit 5) or of the filtered discharge-proof input (reason bit 6) sets a latch that vetoes HV until a clear is accepted.
- R8: When the protection-fault line `prot_ok_i` is low, HV enable is vetoed through reason bit 7. This line is not latched inside the block, and HV returns once the line is high again.
- R9: `hv_en_o` is 1 only when reason bits 0, 1, 5, 6 and 7 are clear and no latch is held. No input combination overrides this veto.
- R10: `expo_permit_o` is `hv_en_o` combined with coolant, fan and thermal all being OK. An exposure starts only on a rising edge of `expo_req_i` while the permit is 1. An edge that arrives while the permit is 0 is ignored, and no exposure starts later until a new rising edge arrives. An exposure ends when `expo_req_i` falls or the permit is lost.
- R11: A clear is accepted on a rising edge of `svc_reset_i` only when `evt_ack_i` is 1 and inputs 0 through 6 are all filtered OK. An accepted clear pulses `clear_ack_o` for one cycle and releases every latch. When a clear is refused, the latches stay.
- R12: `reason_o` bit map: 0 e-stop, 1 door, 2 coolant, 3 fan, 4 thermal, 5 insulation, 6 proof, 7 protection fault. A bit is 1 when the filtered input is low or its latch is held. When `reason_o` goes from all zeros to nonzero, `first_cause_o` takes the lowest newly set bit (one-hot) and `deny_stamp_o` takes the free-running counter value at that edge. Both hold until the next such transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| estop_ok_i | input | 1 | Emergency-stop loop intact |
| door_ok_i | input | 1 | Door/cover closed |
| coolant_ok_i | input | 1 | Coolant flow OK |
| fan_ok_i | input | 1 | Fan/rotor OK |
| thermal_ok_i | input | 1 | Thermal limit not reached |
| insul_ok_i | input | 1 | Insulation monitor not inhibiting |
| proof_ok_i | input | 1 | Discharge proof passing |
| prot_ok_i | input | 1 | Protection fault line clear |
| expo_req_i | input | 1 | Exposure command |
| svc_reset_i | input | 1 | Service reset request |
| evt_ack_i | input | 1 | Event acknowledged |
| hv_en_o | output | 1 | HV stage enable |
| expo_permit_o | output | 1 | Exposure permitted |
| expo_active_o | output | 1 | Exposure running |
| clear_ack_o | output | 1 | One-cycle pulse: clear accepted |
| latched_o | output | 1 | At least one latch is held |
| reason_o | output | 8 | Live denial bits |
| first_cause_o | output | 8 | First cause of the current denial, one-hot |
| deny_stamp_o | output | STAMP_W | Counter value at the start of the denial |

## Verification
A wrong latch bit appears at the ports as a reason bit that stays set after its input has returned, and as HV enable staying low. This is visible a few cycles after the filter settles. A filter counter with the wrong length shows up as a short door glitch that drops HV, or as a real drop that arrives a cycle early or late. A faulty coolant drop counter shows up as a latch on the wrong drop. The exposure start logic is exercised with command edges that arrive while the permit is low; a wrong start shows as an `expo_active_o` that rises without a fresh edge. The timestamp path is checked by comparing two stamps against the number of cycles the bench counted between the two events.

// File: rtl/hvp_pkg.sv
package hvp_pkg;
   localparam int unsigned NSRC        = 8;
   localparam int unsigned IDX_ESTOP   = 0;
   localparam int unsigned IDX_DOOR    = 1;
   localparam int unsigned IDX_COOL    = 2;
   localparam int unsigned IDX_FAN     = 3;
   localparam int unsigned IDX_THERM   = 4;
   localparam int unsigned IDX_INSUL   = 5;
   localparam int unsigned IDX_PROOF   = 6;
   localparam int unsigned IDX_PROT    = 7;

   typedef logic [NSRC-1:0] src_vec_t;

   // sources that veto the HV stage directly
   localparam src_vec_t HV_MASK  = 8'b1110_0011;
   // operational permits that only gate exposure
   localparam src_vec_t OPS_MASK = 8'b0001_1100;
   // sources that must be OK before a clear is accepted
   localparam src_vec_t CLR_MASK = 8'b0111_1111;

   function automatic src_vec_t lowest_set(input src_vec_t v);
      return v & (~v + src_vec_t'(1));
   endfunction
endpackage

// File: rtl/hvp_deglitch.sv
module hvp_deglitch #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic din_i,
   output logic dout_o
);
   localparam int unsigned CW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
   localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("hvp_deglitch: DEPTH must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          out_q;

   // output moves to the input only after DEPTH disagreeing samples
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (din_i == out_q) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         out_q <= din_i;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign dout_o = out_q;

   // R3: filtered value only ever moves to the value the input had
   assert_flt_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(out_q) |-> (out_q == $past(din_i)));
endmodule

// File: rtl/hvp_drop_tracker.sv
module hvp_drop_tracker #(
   parameter int unsigned DROPS  = 3,
   parameter int unsigned CALM   = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ok_i,
   input  logic clr_i,
   output logic trip_o
);
   localparam int unsigned DW = $clog2(DROPS + 1);
   localparam int unsigned SW = $clog2(CALM + 1);
   localparam logic [DW-1:0] DMAX    = DW'(DROPS);
   localparam logic [DW-1:0] DARM    = DW'(DROPS - 1);
   localparam logic [SW-1:0] CALMMAX = SW'(CALM);

   if (DROPS < 1) begin : g_bad_drops
      $error("hvp_drop_tracker: DROPS must be at least 1");
   end
   if (CALM < 1) begin : g_bad_calm
      $error("hvp_drop_tracker: CALM must be at least 1");
   end

   logic          prev_q;
   logic [DW-1:0] drops_q;
   logic [SW-1:0] calm_q;
   logic          fall;

   assign fall = prev_q & ~ok_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q  <= 1'b0;
         drops_q <= '0;
         calm_q  <= '0;
      end else begin
         prev_q <= ok_i;
         if (clr_i) begin
            drops_q <= '0;
            calm_q  <= '0;
         end else if (fall) begin
            if (drops_q != DMAX) drops_q <= drops_q + DW'(1);
            calm_q <= '0;
         end else if (ok_i) begin
            if (calm_q == CALMMAX) drops_q <= '0;
            else                   calm_q  <= calm_q + SW'(1);
         end else begin
            calm_q <= '0;
         end
      end
   end

   assign trip_o = fall & (drops_q >= DARM);

   // R5: a trip needs the input to have been OK one cycle earlier
   assert_trip_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip_o |-> ($past(ok_i) && !ok_i));
endmodule

// File: rtl/hvp_cause_log.sv
module hvp_cause_log
   import hvp_pkg::*;
#(
   parameter int unsigned STAMP_W = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  src_vec_t           reason_d_i,
   output src_vec_t           reason_o,
   output src_vec_t           first_o,
   output logic [STAMP_W-1:0] stamp_o
);
   logic [STAMP_W-1:0] tick_q;
   src_vec_t           reason_q;
   src_vec_t           first_q;
   logic [STAMP_W-1:0] stamp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tick_q   <= '0;
         reason_q <= '1;
         first_q  <= '0;
         stamp_q  <= '0;
      end else begin
         tick_q   <= tick_q + STAMP_W'(1);
         reason_q <= reason_d_i;
         if ((reason_q == '0) && (reason_d_i != '0)) begin
            first_q <= lowest_set(reason_d_i);
            stamp_q <= tick_q;
         end
      end
   end

   assign reason_o = reason_q;
   assign first_o  = first_q;
   assign stamp_o  = stamp_q;

   // R12: first cause names at most one source
   assert_first_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(first_q));
   // R12: a new first cause is only taken when a denial starts from a clean state
   assert_first_from_clean_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(first_q) |-> ($past(reason_q) == '0));
endmodule

// File: rtl/hv_permit_arbiter.sv
module hv_permit_arbiter
   import hvp_pkg::*;
#(
   parameter int unsigned DOOR_DEPTH  = 3,
   parameter int unsigned COOL_DEPTH  = 16,
   parameter int unsigned FAN_DEPTH   = 16,
   parameter int unsigned THERM_DEPTH = 32,
   parameter int unsigned INSUL_DEPTH = 8,
   parameter int unsigned PROOF_DEPTH = 8,
   parameter int unsigned COOL_DROPS  = 3,
   parameter int unsigned COOL_CALM   = 64,
   parameter int unsigned STAMP_W     = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               estop_ok_i,
   input  logic               door_ok_i,
   input  logic               coolant_ok_i,
   input  logic               fan_ok_i,
   input  logic               thermal_ok_i,
   input  logic               insul_ok_i,
   input  logic               proof_ok_i,
   input  logic               prot_ok_i,
   input  logic               expo_req_i,
   input  logic               svc_reset_i,
   input  logic               evt_ack_i,
   output logic               hv_en_o,
   output logic               expo_permit_o,
   output logic               expo_active_o,
   output logic               clear_ack_o,
   output logic               latched_o,
   output logic [7:0]         reason_o,
   output logic [7:0]         first_cause_o,
   output logic [STAMP_W-1:0] deny_stamp_o
);
   if (STAMP_W < 8 || STAMP_W > 48) begin : g_bad_stamp
      $error("hv_permit_arbiter: STAMP_W out of range 8..48");
   end
   if (DOOR_DEPTH > 64) begin : g_bad_door
      $error("hv_permit_arbiter: door filter must stay a short deglitch");
   end

   // filter length per source; zero means the source is taken unfiltered
   function automatic int unsigned depth_of(input int unsigned idx);
      case (idx)
         IDX_DOOR:  return DOOR_DEPTH;
         IDX_COOL:  return COOL_DEPTH;
         IDX_FAN:   return FAN_DEPTH;
         IDX_THERM: return THERM_DEPTH;
         IDX_INSUL: return INSUL_DEPTH;
         IDX_PROOF: return PROOF_DEPTH;
         default:   return 0;
      endcase
   endfunction

   src_vec_t raw;
   src_vec_t flt;

   always_comb begin
      raw            = '0;
      raw[IDX_ESTOP] = estop_ok_i;
      raw[IDX_DOOR]  = door_ok_i;
      raw[IDX_COOL]  = coolant_ok_i;
      raw[IDX_FAN]   = fan_ok_i;
      raw[IDX_THERM] = thermal_ok_i;
      raw[IDX_INSUL] = insul_ok_i;
      raw[IDX_PROOF] = proof_ok_i;
      raw[IDX_PROT]  = prot_ok_i;
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      localparam int unsigned D = depth_of(g);
      if (D == 0) begin : g_direct
         assign flt[g] = raw[g];
      end else begin : g_filter
         hvp_deglitch #(.DEPTH(D)) u_flt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .din_i  (raw[g]),
            .dout_o (flt[g])
         );
      end
   end

   // ---------------- latch bookkeeping ----------------
   src_vec_t latch_q;
   src_vec_t latch_set;
   logic     latch_any;
   logic     insul_prev_q;
   logic     proof_prev_q;
   logic     svc_q;
   logic     clr_ok;
   logic     cool_trip;
   logic     expo_q;
   logic     req_q;

   hvp_drop_tracker #(.DROPS(COOL_DROPS), .CALM(COOL_CALM)) u_cool_drops (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ok_i   (flt[IDX_COOL]),
      .clr_i  (clr_ok),
      .trip_o (cool_trip)
   );

   always_comb begin
      latch_set            = '0;
      latch_set[IDX_ESTOP] = ~flt[IDX_ESTOP];
      latch_set[IDX_DOOR]  = ~flt[IDX_DOOR] & expo_q;
      latch_set[IDX_COOL]  = cool_trip;
      latch_set[IDX_FAN]   = ~flt[IDX_FAN] & expo_q;
      latch_set[IDX_INSUL] = insul_prev_q & ~flt[IDX_INSUL];
      latch_set[IDX_PROOF] = proof_prev_q & ~flt[IDX_PROOF];
   end

   assign latch_any = |latch_q;
   assign clr_ok    = svc_reset_i & ~svc_q & evt_ack_i & (((~flt) & CLR_MASK) == '0);

   // ---------------- permission decision ----------------
   src_vec_t reason_d;
   logic     hv_ok;
   logic     permit_d;

   assign reason_d = (~flt) | latch_q;
   assign hv_ok    = ((reason_d & HV_MASK) == '0) & ~latch_any;
   assign permit_d = hv_ok & ((reason_d & OPS_MASK) == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         latch_q       <= '0;
         insul_prev_q  <= 1'b0;
         proof_prev_q  <= 1'b0;
         svc_q         <= 1'b1;
         req_q         <= 1'b1;
         expo_q        <= 1'b0;
         hv_en_o       <= 1'b0;
         expo_permit_o <= 1'b0;
         clear_ack_o   <= 1'b0;
      end else begin
         insul_prev_q  <= flt[IDX_INSUL];
         proof_prev_q  <= flt[IDX_PROOF];
         svc_q         <= svc_reset_i;
         req_q         <= expo_req_i;
         hv_en_o       <= hv_ok;
         expo_permit_o <= permit_d;
         clear_ack_o   <= clr_ok;
         if (clr_ok) latch_q <= latch_set;
         else        latch_q <= latch_q | latch_set;
         if (!expo_req_i || !permit_d)
            expo_q <= 1'b0;
         else if (!req_q && expo_permit_o)
            expo_q <= 1'b1;
      end
   end

   assign expo_active_o = expo_q;
   assign latched_o     = latch_any;

   hvp_cause_log #(.STAMP_W(STAMP_W)) u_cause (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .reason_d_i (reason_d),
      .reason_o   (reason_o),
      .first_o    (first_cause_o),
      .stamp_o    (deny_stamp_o)
   );

   // R2: an open e-stop loop removes HV on the very next edge
   assert_estop_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !estop_ok_i |=> !hv_en_o);
   // R9: HV never on while a direct veto source is reported
   assert_hv_veto_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hv_en_o |-> ((reason_o & HV_MASK) == '0));
   // R9: a held latch keeps HV off on the following edge
   assert_latch_blocks_hv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latched_o |=> !hv_en_o);
   // R10: permit implies HV enable
   assert_permit_needs_hv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expo_permit_o |-> hv_en_o);
   // R10: an exposure begins only from a command edge under permit
   assert_start_on_permit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(expo_active_o) |-> ($past(expo_permit_o) && $past(expo_req_i)));
   // R11: a clear pulse needs the reset request, acknowledge and intact e-stop
   assert_clear_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_ack_o |-> $past(svc_reset_i && evt_ack_i && estop_ok_i));
   // R11: clear acknowledge is a single-cycle pulse
   assert_clear_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_ack_o |=> !clear_ack_o);
endmodule

// File: tb/hv_permit_arbiter_tb_top.sv
`timescale 1ns/1ps
module hv_permit_arbiter_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic estop = 1'b1, door = 1'b0, cool = 1'b0, fan = 1'b0, therm = 1'b0;
   logic insul = 1'b0, proof = 1'b0, prot = 1'b0;
   logic req = 1'b0, svc = 1'b0, ack = 1'b0;
   logic hv_en, permit, active, clr_ack, latched;
   logic [7:0]  reason, first;
   logic [15:0] stamp;

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc++;

   hv_permit_arbiter dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .estop_ok_i(estop), .door_ok_i(door), .coolant_ok_i(cool), .fan_ok_i(fan),
      .thermal_ok_i(therm), .insul_ok_i(insul), .proof_ok_i(proof), .prot_ok_i(prot),
      .expo_req_i(req), .svc_reset_i(svc), .evt_ack_i(ack),
      .hv_en_o(hv_en), .expo_permit_o(permit), .expo_active_o(active),
      .clear_ack_o(clr_ack), .latched_o(latched), .reason_o(reason),
      .first_cause_o(first), .deny_stamp_o(stamp)
   );

   typedef struct {
      string      req;
      logic       hv;
      logic       pm;
      logic       act;
      logic       lat;
      logic [7:0] rsn;
   } exp_t;

   exp_t sb_q[$];
   int total = 0;
   int bad   = 0;

   // monitor: pops each expected item and compares at a falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if ({hv_en, permit, active, latched, reason} !== {e.hv, e.pm, e.act, e.lat, e.rsn}) begin
               bad++;
               $display("FAIL %s: hv=%0b pm=%0b act=%0b lat=%0b rsn=%02h expected hv=%0b pm=%0b act=%0b lat=%0b rsn=%02h",
                        e.req, hv_en, permit, active, latched, reason, e.hv, e.pm, e.act, e.lat, e.rsn);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_st(input string r, input logic hv, input logic pm, input logic act,
                            input logic lat, input logic [7:0] rsn);
      exp_t e;
      e.req = r; e.hv = hv; e.pm = pm; e.act = act; e.lat = lat; e.rsn = rsn;
      sb_q.push_back(e);
      wait (sb_q.size() == 0);
   endtask

   task automatic chk(input string r, input logic [31:0] act_v, input logic [31:0] exp_v);
      total++;
      if (act_v !== exp_v) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", r, act_v, exp_v);
      end
   endtask

   task automatic do_clear();
      ack = 1'b1; svc = 1'b1;
      tick(1);
      svc = 1'b0; ack = 1'b0;
      tick(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int c1, c2;
      logic [15:0] s1, s2;
      tick(3);
      expect_st("R1 reset state", 0, 0, 0, 0, 8'hFF);
      door = 1; cool = 1; fan = 1; therm = 1; insul = 1; proof = 1; prot = 1;
      tick(1);
      rst_n = 1'b1;
      tick(1);
      expect_st("R1 filters start not OK", 0, 0, 0, 0, 8'h7E);
      tick(40);
      expect_st("R9 all OK gives HV", 1, 1, 0, 0, 8'h00);

      // exposure and door glitch
      req = 1; tick(2);
      expect_st("R10 exposure starts on edge", 1, 1, 1, 0, 8'h00);
      door = 0; tick(2); door = 1; tick(5);
      expect_st("R3 short door glitch ignored", 1, 1, 1, 0, 8'h00);
      door = 0; tick(6);
      expect_st("R4 door drop in exposure", 0, 0, 0, 1, 8'h02);
      chk("R12 first cause door", {24'h0, first}, 32'h02);
      door = 1; tick(6);
      expect_st("R4 door latch holds", 0, 0, 0, 1, 8'h02);

      // refused clear (no acknowledge)
      svc = 1; tick(2);
      chk("R11 no clear without ack", {31'h0, clr_ack}, 32'h0);
      svc = 0; tick(2);
      expect_st("R11 latch kept after refusal", 0, 0, 0, 1, 8'h02);
      ack = 1; svc = 1; tick(1);
      chk("R11 clear pulse", {31'h0, clr_ack}, 32'h1);
      svc = 0; tick(1);
      chk("R11 clear pulse one cycle", {31'h0, clr_ack}, 32'h0);
      ack = 0; tick(3);
      expect_st("R11 clear restores HV, R10 no restart", 1, 1, 0, 0, 8'h00);
      req = 0; tick(2);

      door = 0; tick(6);
      expect_st("R3 idle door drop", 0, 0, 0, 0, 8'h02);
      door = 1; tick(6);
      expect_st("R3 idle door no latch", 1, 1, 0, 0, 8'h00);

      // e-stop latency, latch and timestamps
      c1 = cyc; estop = 0; tick(1);
      chk("R2 HV off next edge", {31'h0, hv_en}, 32'h0);
      estop = 1; tick(3);
      expect_st("R2 estop latched", 0, 0, 0, 1, 8'h01);
      chk("R12 first cause estop", {24'h0, first}, 32'h01);
      s1 = stamp;
      do_clear(); tick(3);
      expect_st("R9 HV back after estop clear", 1, 1, 0, 0, 8'h00);
      tick(17);
      c2 = cyc; estop = 0; tick(1); estop = 1; tick(2);
      s2 = stamp;
      chk("R12 stamp distance", {16'h0, 16'(s2 - s1)}, {16'h0, 16'(c2 - c1)});
      do_clear(); tick(3);

      // thermal only withdraws permit; command edge ignored
      therm = 0; tick(40);
      expect_st("R6 thermal keeps HV", 1, 0, 0, 0, 8'h10);
      chk("R12 first cause thermal", {24'h0, first}, 32'h10);
      req = 1; tick(3);
      expect_st("R10 command ignored without permit", 1, 0, 0, 0, 8'h10);
      therm = 1; tick(40);
      expect_st("R10 no late start", 1, 1, 0, 0, 8'h00);
      req = 0; tick(2); req = 1; tick(2);
      expect_st("R10 fresh edge starts", 1, 1, 1, 0, 8'h00);

      // fan
      fan = 0; tick(20);
      expect_st("R6 fan drop in exposure latches", 0, 0, 0, 1, 8'h08);
      fan = 1; tick(20);
      expect_st("R6 fan latch holds", 0, 0, 0, 1, 8'h08);
      req = 0; do_clear(); tick(3);
      expect_st("R9 HV after fan clear", 1, 1, 0, 0, 8'h00);
      fan = 0; tick(20);
      expect_st("R6 idle fan drop", 1, 0, 0, 0, 8'h08);
      fan = 1; tick(20);
      expect_st("R6 idle fan no latch", 1, 1, 0, 0, 8'h00);

      // coolant repeated drops
      for (int i = 0; i < 2; i++) begin
         cool = 0; tick(20); cool = 1; tick(20);
      end
      expect_st("R5 two drops no latch", 1, 1, 0, 0, 8'h00);
      cool = 0; tick(20);
      expect_st("R5 third drop latches", 0, 0, 0, 1, 8'h04);
      cool = 1; tick(20);
      expect_st("R5 coolant latch holds", 0, 0, 0, 1, 8'h04);
      do_clear(); tick(3);
      expect_st("R5 cleared", 1, 1, 0, 0, 8'h00);
      for (int i = 0; i < 2; i++) begin
         cool = 0; tick(20); cool = 1; tick(20);
      end
      tick(100);
      for (int i = 0; i < 2; i++) begin
         cool = 0; tick(20); cool = 1; tick(20);
      end
      expect_st("R5 calm period resets count", 1, 1, 0, 0, 8'h00);

      // insulation and proof
      insul = 0; tick(12);
      expect_st("R7 insulation latches", 0, 0, 0, 1, 8'h20);
      insul = 1; tick(12);
      expect_st("R7 insulation latch holds", 0, 0, 0, 1, 8'h20);
      do_clear(); tick(3);
      proof = 0; tick(12);
      expect_st("R7 proof latches", 0, 0, 0, 1, 8'h40);
      proof = 1; tick(12);
      door = 0; tick(6);
      do_clear();
      door = 1; tick(6);
      expect_st("R11 clear refused with door open", 0, 0, 0, 1, 8'h40);
      do_clear(); tick(3);
      expect_st("R11 proof cleared", 1, 1, 0, 0, 8'h00);

      // protection fault line
      prot = 0; tick(2);
      expect_st("R8 fault vetoes HV", 0, 0, 0, 0, 8'h80);
      prot = 1; tick(3);
      expect_st("R8 fault release", 1, 1, 0, 0, 8'h00);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule